// File: doc/BRIEF.md
# Dual Time Base Counter Unit

This block keeps two independent 24-bit time base counters. Match and capture channels elsewhere in the chip use them as their time references. Each counter has its own power-of-two prescaler and its own choice of what advances it:

- **Counter A** counts either every system clock or rising edges of an external clock pin.
- **Counter B** can do the same, can also follow a tick stream from angle-clock hardware, or can be held still.

The external pin passes through a two-flop synchronizer. Its rising edges are detected in the system clock domain.

Software can load a new value into either counter at any time. A load wins over an increment that falls in the same cycle. Each consuming channel has a select bit that picks counter A or counter B. The selected value appears on that channel's slice of a flat output bus, with no register in the path.

Top module: `dual_timebase`

## Requirements
- R1: While reset is asserted, both counters read 0.
- R2: A counter whose source is the system clock (`cfg_src_a` = 0, or `cfg_src_b` = 2'd0) advances once per 2^div clock cycles. The 3-bit div field gives ratios 1 to 128. After a load, m further cycles raise the value by floor(m / 2^div).
- R3: A counter whose source is the external pin (`cfg_src_a` = 1, or `cfg_src_b` = 2'd1) counts rising edges of the pin, divided by 2^div. Each edge must be held high and then low for at least two clock cycles. A counted edge shows on the counter three clock edges after the pin rises.
- R4: With `cfg_src_b` = 2'd2, counter B counts cycles in which `angle_tick` is high, divided by 2^div. Counter A is never affected by `angle_tick`.
- R5: With `cfg_src_b` = 2'd3, counter B holds its value unless it is loaded.
- R6: Both counters wrap from 24'hFFFFFF to 0.
- R7: A load sets the counter to the load value on the next clock edge, whatever increment was due in that cycle, and restarts its prescaler from zero.
- R8: A change in a counter's div or source field restarts that counter's prescaler. The cycle in which the change is seen never advances the counter.
- R9: Channel i outputs counter A on bits [24i+23:24i] when `ch_sel[i]` is 0, and counter B when it is 1, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_pin | input | 1 | Asynchronous external clock pin |
| angle_tick | input | 1 | Single-cycle advance pulses from angle hardware |
| cfg_src_a | input | 1 | Counter A source: 0 system clock, 1 external pin |
| cfg_div_a | input | 3 | Counter A prescaler exponent |
| cfg_src_b | input | 2 | Counter B source: 0 system, 1 pin, 2 angle, 3 hold |
| cfg_div_b | input | 3 | Counter B prescaler exponent |
| ld_a_en | input | 1 | Load strobe for counter A |
| ld_a_val | input | 24 | Load value for counter A |
| ld_b_en | input | 1 | Load strobe for counter B |
| ld_b_val | input | 24 | Load value for counter B |
| ch_sel | input | NCH | Per-channel counter select |
| ch_time | output | 24*NCH | Per-channel selected time value |
| cnt_a | output | 24 | Counter A value |
| cnt_b | output | 24 | Counter B value |

## Verification
The bench builds the block with its default parameters: 24-bit counters, a 3-bit prescaler exponent and four channels.

The three-bit exponent allows a full sweep of all eight divide ratios on both counters, with expected counts computed as floor divisions from the load point. Four channels give only sixteen select patterns, so every one of them is compared against both counters.

The same small setup also reaches the wrap point, the prescaler restart after a load or a configuration change, and the pin synchronizer latency.

// File: rtl/dual_timebase.sv
module dual_timebase #(
  parameter int CW  = 24,
  parameter int DW  = 3,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_pin,
  input  logic              angle_tick,
  input  logic              cfg_src_a,
  input  logic [DW-1:0]     cfg_div_a,
  input  logic [1:0]        cfg_src_b,
  input  logic [DW-1:0]     cfg_div_b,
  input  logic              ld_a_en,
  input  logic [CW-1:0]     ld_a_val,
  input  logic              ld_b_en,
  input  logic [CW-1:0]     ld_b_val,
  input  logic [NCH-1:0]    ch_sel,
  output logic [CW*NCH-1:0] ch_time,
  output logic [CW-1:0]     cnt_a,
  output logic [CW-1:0]     cnt_b
);
  localparam int PW = (1 << DW) - 1;
  localparam int FW = DW + 2;

  logic [2:0] ext_sync;
  logic       ext_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_clk_pin};

  assign ext_rise = ext_sync[1] & ~ext_sync[2];

  logic          ev   [2];
  logic          ld   [2];
  logic [CW-1:0] ldv  [2];
  logic [DW-1:0] div  [2];
  logic [FW-1:0] cfg  [2];
  logic [CW-1:0] cnt  [2];

  assign ev[0]  = cfg_src_a ? ext_rise : 1'b1;
  assign ev[1]  = (cfg_src_b == 2'd0) ? 1'b1 :
                  (cfg_src_b == 2'd1) ? ext_rise :
                  (cfg_src_b == 2'd2) ? angle_tick : 1'b0;
  assign ld[0]  = ld_a_en;
  assign ld[1]  = ld_b_en;
  assign ldv[0] = ld_a_val;
  assign ldv[1] = ld_b_val;
  assign div[0] = cfg_div_a;
  assign div[1] = cfg_div_b;
  assign cfg[0] = {1'b0, cfg_src_a, cfg_div_a};
  assign cfg[1] = {cfg_src_b, cfg_div_b};

  for (genvar i = 0; i < 2; i++) begin : g_ctr
    logic [PW-1:0] pc;
    logic [PW-1:0] last;
    logic [FW-1:0] cfg_q;

    assign last = ~({PW{1'b1}} << div[i]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt[i] <= '0;
        pc     <= '0;
        cfg_q  <= '0;
      end else begin
        cfg_q <= cfg[i];
        if (ld[i]) begin
          cnt[i] <= ldv[i];
          pc     <= '0;
        end else if (cfg[i] != cfg_q) begin
          pc <= '0;
        end else if (ev[i]) begin
          if (pc == last) begin
            pc     <= '0;
            cnt[i] <= cnt[i] + 1'b1;
          end else begin
            pc <= pc + 1'b1;
          end
        end
      end
  end

  assign cnt_a = cnt[0];
  assign cnt_b = cnt[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_time[c*CW +: CW] = ch_sel[c] ? cnt[1] : cnt[0];
  end
endmodule

// File: rtl/dual_timebase_chk.sv
module dual_timebase_chk #(
  parameter int CW  = 24,
  parameter int DW  = 3,
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              angle_tick,
  input logic              cfg_src_a,
  input logic [DW-1:0]     cfg_div_a,
  input logic [1:0]        cfg_src_b,
  input logic              ld_a_en,
  input logic [CW-1:0]     ld_a_val,
  input logic              ld_b_en,
  input logic [CW-1:0]     ld_b_val,
  input logic [NCH-1:0]    ch_sel,
  input logic [CW*NCH-1:0] ch_time,
  input logic [CW-1:0]     cnt_a,
  input logic [CW-1:0]     cnt_b
);
  // R7
  load_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a_en |=> cnt_a == $past(ld_a_val));

  // R7
  load_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_b_en |=> cnt_b == $past(ld_b_val));

  // R6
  step_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_a_en |=> (cnt_a == $past(cnt_a)) || (cnt_a == $past(cnt_a) + 1'b1));

  // R5
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src_b == 2'd3 && $past(cfg_src_b) == 2'd3 && !ld_b_en) |=> $stable(cnt_b));

  // R4
  angle_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src_b == 2'd2 && !angle_tick && !ld_b_en) |=> $stable(cnt_b));

  // R8
  cfg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_div_a != $past(cfg_div_a) || cfg_src_a != $past(cfg_src_a)) && !ld_a_en)
      |=> $stable(cnt_a));

  // R9
  ch0_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_time[CW-1:0] == (ch_sel[0] ? cnt_b : cnt_a));
endmodule

bind dual_timebase dual_timebase_chk #(.CW(CW), .DW(DW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .angle_tick(angle_tick),
  .cfg_src_a(cfg_src_a), .cfg_div_a(cfg_div_a), .cfg_src_b(cfg_src_b),
  .ld_a_en(ld_a_en), .ld_a_val(ld_a_val), .ld_b_en(ld_b_en), .ld_b_val(ld_b_val),
  .ch_sel(ch_sel), .ch_time(ch_time), .cnt_a(cnt_a), .cnt_b(cnt_b)
);

// File: tb/dual_timebase_tb.sv
module dual_timebase_tb;
  localparam int CW = 24, DW = 3, NCH = 4;

  logic clk = 0, rst_n = 0;
  logic ext_clk_pin = 0, angle_tick = 0;
  logic cfg_src_a = 0;
  logic [DW-1:0] cfg_div_a = 0, cfg_div_b = 0;
  logic [1:0] cfg_src_b = 0;
  logic ld_a_en = 0, ld_b_en = 0;
  logic [CW-1:0] ld_a_val = 0, ld_b_val = 0;
  logic [NCH-1:0] ch_sel = 0;
  logic [CW*NCH-1:0] ch_time;
  logic [CW-1:0] cnt_a, cnt_b;
  int checks = 0, errors = 0, cyc = 0;

  dual_timebase #(.CW(CW), .DW(DW), .NCH(NCH)) u_dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected end before it", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [CW-1:0] va, input logic [CW-1:0] vb);
    ld_a_en = 1; ld_b_en = 1; ld_a_val = va; ld_b_val = vb;
    step(1);
    ld_a_en = 0; ld_b_en = 0;
  endtask

  task automatic pin_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      ext_clk_pin = 1; step(2);
      ext_clk_pin = 0; step(2);
    end
  endtask

  task automatic angle_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      angle_tick = 1; step(1);
      angle_tick = 0; step(1);
    end
  endtask

  initial begin
    step(2);
    chk("R1 cnt_a in reset", cnt_a, 0);
    chk("R1 cnt_b in reset", cnt_b, 0);
    rst_n = 1;
    step(2);

    // R2: sweep all ratios on both counters with system-clock source
    for (int d = 0; d < 8; d++) begin
      for (int j = 0; j < 4; j++) begin
        int r = 1 << d;
        int m = (j == 0) ? 0 : (j == 1) ? r - 1 : (j == 2) ? r : 3 * r + r / 2;
        cfg_src_a = 0; cfg_src_b = 2'd0;
        cfg_div_a = DW'(d); cfg_div_b = DW'(7 - d);
        load(24'h001000 + 24'(d), 24'h200000);
        step(m);
        chk("R2 counter A sysclk", cnt_a, 24'h001000 + 24'(d) + 24'(m / r));
        chk("R2 counter B sysclk", cnt_b, 24'h200000 + 24'(m / (1 << (7 - d))));
      end
    end

    // R6: wrap
    cfg_div_a = 0; cfg_div_b = 1;
    load(24'hFFFFFF, 24'hFFFFFE);
    step(1);
    chk("R6 counter A wrap", cnt_a, 24'h000000);
    step(3);
    chk("R6 counter B wrap", cnt_b, 24'h000000);

    // R3: external pin source
    cfg_src_a = 1; cfg_src_b = 2'd1; cfg_div_a = 0; cfg_div_b = 1;
    load(0, 0);
    ext_clk_pin = 1; step(2);
    chk("R3 not yet counted after two edges", cnt_a, 0);
    step(1);
    chk("R3 counted on third edge", cnt_a, 1);
    ext_clk_pin = 0; step(2);
    pin_pulses(6);
    step(4);
    chk("R3 counter A pin edges", cnt_a, 7);
    chk("R3 counter B pin edges div2", cnt_b, 3);

    // R4: angle ticks advance B only
    cfg_src_a = 1; cfg_src_b = 2'd2; cfg_div_b = 0;
    load(24'h000050, 0);
    angle_pulses(5);
    chk("R4 counter B angle ticks", cnt_b, 5);
    chk("R4 counter A ignores angle ticks", cnt_a, 24'h000050);
    cfg_div_b = 1;
    load(24'h000050, 0);
    angle_pulses(6);
    chk("R4 counter B angle ticks div2", cnt_b, 3);
    cfg_src_a = 0;
    load(0, 0);
    angle_tick = 1; step(4); angle_tick = 0;
    chk("R4 counter A sysclk unaffected by held tick", cnt_a, 4);

    // R5: hold mode
    cfg_src_a = 1; cfg_src_b = 2'd3; cfg_div_b = 0;
    load(0, 24'h000077);
    angle_pulses(3);
    pin_pulses(3);
    step(10);
    chk("R5 counter B held", cnt_b, 24'h000077);

    // R7: load priority and prescaler restart
    cfg_src_a = 0; cfg_src_b = 2'd0; cfg_div_a = 0; cfg_div_b = 0;
    step(2);
    ld_a_en = 1; ld_a_val = 24'h00ABCD; step(5); ld_a_en = 0;
    chk("R7 held load beats increment", cnt_a, 24'h00ABCD);
    cfg_div_a = 2;
    load(0, 0);
    step(3);
    load(24'h00000A, 0);
    step(3);
    chk("R7 prescaler restarted by load", cnt_a, 24'h00000A);
    step(1);
    chk("R7 first increment after load", cnt_a, 24'h00000B);

    // R8: configuration change restarts prescaler
    cfg_div_a = 2;
    load(0, 0);
    step(3);
    cfg_div_a = 3; step(1);
    step(7);
    chk("R8 no increment before full ratio", cnt_a, 0);
    step(1);
    chk("R8 increment after full ratio", cnt_a, 1);
    cfg_src_a = 1; step(1); cfg_src_a = 0; step(1);
    chk("R8 source change cycle does not count", cnt_a, 1);

    // R9: channel select
    cfg_src_a = 1; cfg_src_b = 2'd3;
    load(24'h0A0A0A, 24'h0B0B0B);
    for (int s = 0; s < (1 << NCH); s++) begin
      ch_sel = NCH'(s);
      #1;
      for (int c = 0; c < NCH; c++)
        chk("R9 channel select", ch_time[c*CW +: CW], s[c] ? 24'h0B0B0B : 24'h0A0A0A);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule